// File: doc/BRIEF.md
# Width-Dependent Bidirectional Pin Bank

This block manages a bank of general-purpose pins placed next to a parallel data port. Each pin is set up as an output or an input by a per-pin direction bit. The pins at the low end of the bank are shared with the data port. A wider data word therefore takes more of them, and the set of usable pins shrinks from the bottom as the width code rises. The topmost pins are never taken and are always usable.

Each pin has one level bit, and its meaning depends on the direction. On an output pin, the bit is the value driven on the pad, and software sets it through per-bit write enables. On an input pin, the bit is refreshed every cycle from the pad through a synchronizer, so a readback returns the observed level. When a pin changes from input to output, it drives the last level it captured until software writes a new one. A pin the data port has taken never drives, and it reads back as zero.

Every interface of this block is a level-sensitive control or status pin, so there is no valid/ready handshake and no back-pressure. A write takes effect on the clock edge at which its enable bit is high. Readback is combinational from the stored level bits.

Top module: `gpio_bank`

## Requirements
- R1: While `rst_n` is low, every level bit is 0. `rd_level` and `pad_o` read all zeros whatever the other inputs are.
- R2: `width_code` 0, 1, 2, 3 and 4 select data widths 10, 12, 14, 16 and 18. Pin i is usable when i >= 2*code. Codes 5 to 7 behave like code 4. Pins 8 and 9 are usable under every code.
- R3: For an unusable pin, `pad_oe`, `pad_o` and `rd_level` are 0 whatever its direction bit (1 = output, 0 = input) and its write enable are.
- R4: For a usable output pin, `pad_oe` is 1 and `pad_o` equals its level bit. A write with `wr_be[i]` high loads `wr_data[i]` at that edge.
- R5: A usable output pin with no write enable keeps its level bit unchanged.
- R6: A usable input pin has `pad_oe` 0. Its level bit takes the value of `pad_i` through a two-flop synchronizer, so a pad change shows on `rd_level` after the third rising edge and not earlier.
- R7: Writes to a usable input pin have no effect on its level bit.
- R8: A pin switched from input to output drives the last level it captured, not the current pad value.
- R9: A pin made unusable has its level bit cleared. If it becomes usable again, it reads 0 until it captures or is written.
- R10: Write enables act per bit. Level bits whose `wr_be` bit is low keep their value during a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| width_code | input | 3 | Parallel data width selector |
| dir | input | 10 | Per-pin direction, 1 = output |
| wr_data | input | 10 | Level write data |
| wr_be | input | 10 | Per-bit level write enables |
| pad_i | input | 10 | Pad input levels (asynchronous) |
| pad_o | output | 10 | Pad output levels |
| pad_oe | output | 10 | Pad output enables |
| rd_level | output | 10 | Level bit readback |

## Verification
The bench builds the block with its default parameters: ten pins, two always-usable pins, two pins released per width step, a three-bit width code and two synchronizer stages. With these values, every defined width code and all three out-of-range codes can be selected, and the step from one code to the next releases or takes exactly two pins. Because the synchronizer is two stages deep, the bench can count the capture latency one edge at a time. Separate directed sequences cover the switch from input to output, partial writes, and the clearing of pins taken by the data port.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Pin direction encoding shared by the bank and its pin cells.
  typedef enum logic {
    PIN_IN  = 1'b0,
    PIN_OUT = 1'b1
  } pin_dir_e;

  // Default geometry of the bank.
  localparam int unsigned DEF_NUM_PINS    = 10;
  localparam int unsigned DEF_FIXED_PINS  = 2;
  localparam int unsigned DEF_STEP_PINS   = 2;
  localparam int unsigned DEF_CODE_W      = 3;
  localparam int unsigned DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/gpio_avail_decode.sv
module gpio_avail_decode #(
  parameter int unsigned NUM_PINS   = 10,
  parameter int unsigned FIXED_PINS = 2,
  parameter int unsigned STEP_PINS  = 2,
  parameter int unsigned CODE_W     = 3
) (
  input  logic [CODE_W-1:0]   width_code,
  output logic [NUM_PINS-1:0] avail
);

  localparam int unsigned MAX_CODE = (NUM_PINS - FIXED_PINS) / STEP_PINS;
  localparam int unsigned IDX_W    = $clog2(NUM_PINS + 1);

  logic [CODE_W-1:0] code_clamped;
  logic [IDX_W-1:0]  first_pin;

  // Codes past the widest defined data word saturate to it.
  always_comb begin
    if (width_code > CODE_W'(MAX_CODE)) code_clamped = CODE_W'(MAX_CODE);
    else                                code_clamped = width_code;
    first_pin = IDX_W'(code_clamped) * IDX_W'(STEP_PINS);
  end

  // Usable pins form a run from first_pin up to the top of the bank.
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign avail[i] = (IDX_W'(i) >= first_pin);
  end

  // R2: the fixed pins at the top stay usable under any code.
  always_comb begin
    a_r2_fixed_usable: assert (&avail[NUM_PINS-1 -: FIXED_PINS]);
  end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 10,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[k] <= '0;
      else        chain[k] <= chain[k-1];
    end

    // R6: each stage adds exactly one edge of delay.
    a_r6_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (chain[k] == $past(chain[k-1])));
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_bank_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic avail,
  input  logic dir,
  input  logic we,
  input  logic wdata,
  input  logic sync_in,
  output logic pad_o,
  output logic pad_oe,
  output logic rd
);

  pin_dir_e mode;
  logic     level;

  assign mode = pin_dir_e'(dir);

  // One bit per pin: the drive value on an output, the sampled level on an input.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             level <= 1'b0;
    else if (!avail)        level <= 1'b0;
    else if (mode == PIN_IN) level <= sync_in;
    else if (we)            level <= wdata;
  end

  assign pad_oe = avail & (mode == PIN_OUT);
  assign pad_o  = avail & level;
  assign rd     = avail & level;

  // R6: an input pin loads the synchronized pad level.
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (avail && mode == PIN_IN) |=> (level == $past(sync_in)));

  // R7: a write to an input pin does not reach the level bit.
  a_r7_input_ignores_write: assert property (@(posedge clk) disable iff (!rst_n)
    (avail && mode == PIN_IN && we && (wdata != sync_in)) |=> (level != $past(wdata)));

  // R4: a write to an output pin loads the data bit.
  a_r4_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (avail && mode == PIN_OUT && we) |=> (level == $past(wdata)));

  // R5 / R8: an output pin with no write holds its level.
  a_r5_output_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (avail && mode == PIN_OUT && !we) |=> $stable(level));

  // R9: a pin taken by the data port is cleared.
  a_r9_taken_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !avail |=> (level == 1'b0));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS    = DEF_NUM_PINS,
  parameter int unsigned FIXED_PINS  = DEF_FIXED_PINS,
  parameter int unsigned STEP_PINS   = DEF_STEP_PINS,
  parameter int unsigned CODE_W      = DEF_CODE_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CODE_W-1:0]   width_code,
  input  logic [NUM_PINS-1:0] dir,
  input  logic [NUM_PINS-1:0] wr_data,
  input  logic [NUM_PINS-1:0] wr_be,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] rd_level
);

  logic [NUM_PINS-1:0] avail;
  logic [NUM_PINS-1:0] pad_sync;

  gpio_avail_decode #(
    .NUM_PINS  (NUM_PINS),
    .FIXED_PINS(FIXED_PINS),
    .STEP_PINS (STEP_PINS),
    .CODE_W    (CODE_W)
  ) i_decode (
    .width_code(width_code),
    .avail     (avail)
  );

  gpio_sync #(
    .WIDTH (NUM_PINS),
    .STAGES(SYNC_STAGES)
  ) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_i),
    .q    (pad_sync)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_cell
    gpio_pin_cell i_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .avail  (avail[i]),
      .dir    (dir[i]),
      .we     (wr_be[i]),
      .wdata  (wr_data[i]),
      .sync_in(pad_sync[i]),
      .pad_o  (pad_o[i]),
      .pad_oe (pad_oe[i]),
      .rd     (rd_level[i])
    );

    // R3: a pin the decoder marks as taken neither drives nor reads back.
    a_r3_taken_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !avail[i] |-> (!pad_oe[i] && !pad_o[i] && !rd_level[i]));
  end

  // R2: the fixed top pins always follow their direction bits.
  a_r2_fixed_follow_dir: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe[NUM_PINS-1 -: FIXED_PINS] == dir[NUM_PINS-1 -: FIXED_PINS]);

  // R1: the readback is clear while reset is held.
  always_comb begin
    if (!rst_n) a_r1_reset_clear: assert (rd_level == '0 && pad_o == '0);
  end

endmodule

// File: tb/test_gpio_bank.sv
module test_gpio_bank;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NP = 10;
  localparam int  SYNC = 2;
  localparam int  WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    width_code = '0;
  logic [NP-1:0] dir = '0, wr_data = '0, wr_be = '0, pad_i = '0;
  logic [NP-1:0] pad_o, pad_oe, rd_level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank i_gpio_bank (
    .clk(clk), .rst_n(rst_n), .width_code(width_code), .dir(dir),
    .wr_data(wr_data), .wr_be(wr_be), .pad_i(pad_i),
    .pad_o(pad_o), .pad_oe(pad_oe), .rd_level(rd_level)
  );

  // Usable pins from R2: pin i usable when i >= 2*min(code,4).
  function automatic logic [NP-1:0] usable(input logic [2:0] code);
    int first;
    logic [NP-1:0] m;
    first = ((code > 3'd4) ? 4 : int'(code)) * 2;
    for (int i = 0; i < NP; i++) m[i] = (i >= first);
    return m;
  endfunction

  // code, dir, data, pad  (write enables all high for one cycle)
  localparam logic [32:0] VEC [8] = '{
    {3'd0, 10'h3F0, 10'h2A5, 10'h0F3},
    {3'd1, 10'h0FF, 10'h3C3, 10'h155},
    {3'd2, 10'h300, 10'h1FF, 10'h2AA},
    {3'd3, 10'h3FF, 10'h2D9, 10'h000},
    {3'd4, 10'h3FF, 10'h3FF, 10'h3FF},
    {3'd5, 10'h2AA, 10'h155, 10'h3FF},
    {3'd6, 10'h000, 10'h3FF, 10'h2FF},
    {3'd7, 10'h155, 10'h3FF, 10'h100}
  };

  task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<%0d cycles", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] m, e;

    // R1: reset holds levels at zero even with outputs selected and pads high.
    dir = '1; pad_i = '1; wr_be = '1; wr_data = '1;
    tick(3);
    chk("R1 rd_level", rd_level, '0);
    chk("R1 pad_o", pad_o, '0);
    wr_be = '0; dir = '0; pad_i = '0;
    rst_n = 1'b1;
    tick(2);

    // Vector table: R2 R3 R4 R6 across all width codes.
    foreach (VEC[v]) begin
      width_code = VEC[v][32:30];
      dir        = VEC[v][29:20];
      wr_data    = VEC[v][19:10];
      pad_i      = VEC[v][9:0];
      wr_be      = '1;
      tick(1);
      wr_be = '0;
      tick(SYNC + 2);
      m = usable(width_code);
      e = m & ((dir & wr_data) | (~dir & pad_i));
      chk("R2/R3 pad_oe", pad_oe, m & dir);
      chk("R4 pad_o", pad_o, e);
      chk("R6 rd_level", rd_level, e);
    end

    // R6: capture latency counted edge by edge.
    width_code = 3'd0; dir = '0; pad_i = '0;
    tick(SYNC + 2);
    pad_i = 10'h3FF;
    for (int k = 1; k <= SYNC; k++) begin
      tick(1);
      chk("R6 no early capture", rd_level, 10'h000);
    end
    tick(1);
    chk("R6 capture after third edge", rd_level, 10'h3FF);

    // R8: switch to output drives last captured level, not the new pad.
    pad_i = 10'h155;
    tick(SYNC + 2);
    dir = '1; pad_i = 10'h2AA;
    tick(1);
    chk("R8 pad_oe", pad_oe, 10'h3FF);
    chk("R8 pad_o last captured", pad_o, 10'h155);
    tick(4);
    chk("R5 output holds", pad_o, 10'h155);

    // R10: partial write touches only enabled bits.
    wr_be = 10'h00F; wr_data = 10'h00A;
    tick(1);
    wr_be = '0;
    chk("R10 partial write", rd_level, 10'h15A);

    // R7: writes to input pins are ignored.
    dir = '0; pad_i = 10'h0F0;
    tick(SYNC + 2);
    wr_be = '1; wr_data = 10'h30F;
    tick(1);
    wr_be = '0;
    chk("R7 write ignored", rd_level, 10'h0F0);
    tick(2);
    chk("R7 still input level", rd_level, 10'h0F0);

    // R3 / R9: taking pins silences them and clears their level bits.
    dir = '1; wr_be = '1; wr_data = '1;
    tick(1);
    wr_be = '0;
    chk("R4 all written", rd_level, 10'h3FF);
    width_code = 3'd4;
    tick(1);
    chk("R3 pad_oe taken", pad_oe, 10'h300);
    chk("R3 pad_o taken", pad_o, 10'h300);
    chk("R3 rd_level taken", rd_level, 10'h300);
    width_code = 3'd0;
    tick(1);
    chk("R9 cleared on return", rd_level, 10'h300);
    chk("R9 pad_o on return", pad_o, 10'h300);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule